// File: doc/BRIEF.md
# Synchronous Serial Shift Unit

This block is a half-duplex serial engine that moves one byte per transfer and acts as clock master. It makes a shift clock from the system clock, with one full shift period every six system cycles. On the shared data line it either drives a byte out, least significant bit first, or samples a byte in. The serial clock rests high between transfers. Every transfer opens with a low phase.

A user starts a transmit by presenting a byte with a write strobe while the unit is idle. A receive is started with a separate start strobe. The unit keeps `busy` high during the transfer. It drops `busy` after the eighth rising shift edge and pulses `done` for one system cycle. The byte captured from the line then appears on the parallel output. The line is always sampled, so after a transmit the parallel output holds the value that was seen on the line.

Top module: `sync_shift_unit`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `sclk` is 1 and `busy`, `done` and `sdOe` are 0. A reset during a transfer also clears `rxData` to 0.
- R2: Count the cycles after the accepting clock edge from k=0. During a transfer, `sclk` is low for k/3 even and high for k/3 odd. The eighth rising edge begins cycle k=45. From then on `sclk` stays high while idle.
- R3: A transmit moves the written byte least significant bit first. Bit 0 is driven from k=0 to k=3. Bit j (j from 1 to 7) is driven from k=6j-2 up to the next change, and the last bit is held through k=45. The output bit changes only in the cycle after a rising shift edge, so bits 1 to 7 are valid five system cycles before their rising edge.
- R4: Bit j of the received byte is the line value in the cycle before rising edge j (cycle k=2+6j). The line is captured on that edge, and no hold time after it is needed.
- R5: During a receive, `sdOe` stays 0 for the whole transfer.
- R6: `busy` is 1 for k=0 to 44 and 0 from k=45. `done` is 1 only in cycle k=45, for exactly one cycle. `rxData` holds the captured byte from k=45 on.
- R7: A write or start request that arrives while `busy` is 1 is ignored. The bits on the line, `sdOe`, the timing and the captured byte are all unchanged.
- R8: `sdOe` is 1 during a transmit from k=0 through k=45, which is one cycle after the last rising edge, and 0 again from k=46.
- R9: If `wrValid` and `rxStart` arrive together while idle, the transfer is a transmit of `wrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | Load transmit byte and start a transmit (idle only) |
| wrData | input | 8 | Byte to transmit |
| rxStart | input | 1 | Start a receive (idle only) |
| sdIn | input | 1 | Data line value as seen at the pin |
| sdOut | output | 1 | Data line drive value |
| sdOe | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock, idles high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rxData | output | 8 | Byte captured from the line |

## Verification
The checker assumes that reset is held long enough to settle the state. It also assumes the line value is defined in the cycle before each rising shift edge. The bench drives every bit of a received byte for the full six-cycle window around its edge, so the line is never undefined at a capture. For a transmit, the bench models the pad by feeding `sdOut` back to `sdIn` while `sdOe` is high. The capture logic therefore always sees a driven value. Requests made while busy are issued only at cycles where a design that accepted them would visibly change the line, `sdOe` or the timing.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;
  typedef struct packed {
    logic load;    // transfer accepted this cycle
    logic loadTx;  // accepted transfer is a transmit
    logic sample;  // rising shift edge: capture line
    logic shift;   // one cycle after rising edge: advance tx bit
    logic finish;  // capture of the final bit
  } shift_strobe_t;
endpackage

// File: rtl/sync_shift_ctrl.sv
module sync_shift_ctrl
  import sync_shift_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrValid,
  input  logic          rxStart,
  output shift_strobe_t strobe,
  output logic          sclk,
  output logic          busy,
  output logic          done,
  output logic          sdOe
);
  localparam int PH_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [PH_W-1:0]  phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             phaseEnd;

  assign phaseEnd = (phaseCnt == PH_LAST);

  always_comb begin
    strobe        = '0;
    strobe.load   = !busy && (wrValid || rxStart);
    strobe.loadTx = wrValid;
    strobe.sample = busy && !sclk && phaseEnd;
    strobe.shift  = busy && sclk && (phaseCnt == '0);
    strobe.finish = strobe.sample && (bitCnt == BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sclk     <= 1'b1;
      sdOe     <= 1'b0;
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sdOe <= 1'b0;
        if (strobe.load) begin
          busy     <= 1'b1;
          sclk     <= 1'b0;
          phaseCnt <= '0;
          bitCnt   <= '0;
          sdOe     <= wrValid;
        end
      end else if (phaseEnd) begin
        phaseCnt <= '0;
        sclk     <= ~sclk;
        if (!sclk) begin
          if (bitCnt == BIT_LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_shift_dp.sv
module sync_shift_dp
  import sync_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  shift_strobe_t     strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdIn,
  output logic              sdOut,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {sdIn, rxReg[DATA_W-1:1]};
  assign sdOut  = txReg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      txReg  <= '0;
      rxReg  <= '0;
      rxData <= '0;
    end else begin
      if (strobe.load && strobe.loadTx)
        txReg <= wrData;
      else if (strobe.shift)
        txReg <= {1'b0, txReg[DATA_W-1:1]};
      if (strobe.load)
        rxReg <= '0;
      else if (strobe.sample)
        rxReg <= rxNext;
      if (strobe.finish)
        rxData <= rxNext;
    end
  end
endmodule

// File: rtl/sync_shift_unit.sv
module sync_shift_unit
  import sync_shift_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxStart,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic              sclk,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxData
);
  shift_strobe_t strobe;

  sync_shift_ctrl #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .wrValid(wrValid), .rxStart(rxStart),
    .strobe(strobe), .sclk(sclk), .busy(busy), .done(done), .sdOe(sdOe)
  );

  sync_shift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .sdIn(sdIn), .sdOut(sdOut), .rxData(rxData)
  );
endmodule

// File: rtl/sync_shift_chk.sv
module sync_shift_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdOe,
  input logic sdOut
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (sclk && !busy && !done && !sdOe));

  // R2
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R5
  oe_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sdOe));

  // R3
  tx_change_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sdOe && !$stable(sdOut)) |-> ($past(sclk) && !$past(sclk, 2)));
endmodule

bind sync_shift_unit sync_shift_chk u_chk (.*);

// File: tb/tb_sync_shift_unit.sv
`timescale 1ns/1ps
module tb_sync_shift_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic rxStart = 1'b0;
  logic drv = 1'b0;
  logic sdIn, sdOut, sdOe, sclk, busy, done;
  logic [7:0] rxData;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  assign sdIn = sdOe ? sdOut : drv;

  sync_shift_unit dut (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrData(wrData),
    .rxStart(rxStart), .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe),
    .sclk(sclk), .busy(busy), .done(done), .rxData(rxData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one transfer; injectAt/rstAt < 0 disables that stimulus
  task automatic xfer(input bit isTx, input bit both, input logic [7:0] b,
                      input int injectAt, input int rstAt);
    bit okClk = 1, okBusy = 1, okDone = 1, okOe = 1, okOut = 1;
    int aClk = 0, eClk = 0, aOut = 0, eOut = 0, aOe = 0, eOe = 0;
    bit txMode = isTx || both;
    @(negedge clk);
    wrValid = txMode;
    wrData  = b;
    rxStart = !isTx || both;
    @(posedge clk);
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      wrValid = 1'b0;
      rxStart = 1'b0;
      if (k == injectAt) begin
        wrValid = 1'b1;
        wrData  = ~b;
        rxStart = 1'b1;
      end
      drv = b[(k / 6 > 7) ? 7 : k / 6];
      if (rstAt >= 0 && k == rstAt + 1) begin
        rst = 1'b0;
        // R1 reset during transfer
        chk(sclk && !busy && !done && !sdOe, "R1 mid-transfer reset idle",
            {sclk, busy, done, sdOe}, 4'b1000);
        chk(rxData == 8'h00, "R1 rxData cleared", rxData, 0);
        return;
      end
      begin
        bit eS = (k < 45) ? ((k / 3) % 2 == 1) : 1'b1;
        bit eB = (k < 45);
        bit eD = (k == 45);
        bit eO = txMode && (k <= 45);
        int idx = (k < 4) ? 0 : (((k - 4) / 6 + 1 > 7) ? 7 : (k - 4) / 6 + 1);
        if (sclk !== eS && okClk) begin okClk = 0; aClk = k; eClk = eS; end
        if (busy !== eB) okBusy = 0;
        if (done !== eD) okDone = 0;
        if (sdOe !== eO && okOe) begin okOe = 0; aOe = k; eOe = eO; end
        if (eO && sdOut !== b[idx] && okOut) begin okOut = 0; aOut = sdOut; eOut = b[idx]; end
      end
      if (k == rstAt) rst = 1'b1;
      if (k == 46)
        // R4 captured byte (loopback for transmit)
        chk(rxData == b, "R4 received byte", rxData, b);
    end
    // R2
    chk(okClk, "R2 shift clock pattern", aClk, eClk);
    // R6
    chk(okBusy && okDone, "R6 busy/done timing", {okBusy, okDone}, 2'b11);
    if (txMode) begin
      // R8 / R9
      chk(okOe, both ? "R9 transmit wins, oe" : "R8 transmit oe window", aOe, eOe);
      // R3
      chk(okOut, "R3 transmit bit order", aOut, eOut);
    end else begin
      // R5
      chk(okOe, "R5 oe low during receive", aOe, eOe);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(sclk && !busy && !done && !sdOe && rxData == 0, "R1 reset state",
        {sclk, busy, done, sdOe}, 4'b1000);
    rst = 1'b0;
    for (int v = 0; v < 256; v++) xfer(1'b1, 1'b0, 8'(v), -1, -1);
    for (int v = 0; v < 256; v++) xfer(1'b0, 1'b0, 8'(v ^ 8'h5A), -1, -1);
    // R7 requests while busy, at several points in the transfer
    for (int p = 1; p < 44; p += 7) begin
      xfer(1'b1, 1'b0, 8'hC5, p, -1);
      xfer(1'b0, 1'b0, 8'h3B, p, -1);
    end
    // R9 simultaneous requests
    xfer(1'b1, 1'b1, 8'h96, -1, -1);
    xfer(1'b1, 1'b1, 8'h01, -1, -1);
    // R1 reset mid-transfer, then a clean transfer
    xfer(1'b1, 1'b0, 8'hE7, -1, 20);
    xfer(1'b0, 1'b0, 8'hE7, -1, 33);
    xfer(1'b1, 1'b0, 8'h81, -1, -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule